// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt inputs and hands the processor one request line. Software talks to it through a two-location register window: address 0 is the command location and address 1 is the data location, with an 8-bit data bus for both reads and writes. The controller holds three 8-bit registers: pending requests, in-service levels and a mask. Input 0 has the highest priority and input 7 the lowest. When the processor acknowledges, the controller returns an 8-bit vector one cycle later.

A command write with bit 4 set starts the setup sequence. The data writes that follow carry, in order, the vector base, a cascade word and, if asked for, a mode word. After that, data writes go to the mask. Each in-service level is retired either by end-of-interrupt commands, specific or non-specific, or automatically at acknowledge time. Command-location reads return the pending or in-service register, whichever was last selected. An acknowledge that finds nothing eligible returns the lowest-priority vector as a spurious indication.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the in-service register is empty, command reads return the pending register, and int_req and vec_valid are low.
- R2: A command write with bit 4 set sets the mask to 0xFF, empties the in-service register, selects the pending register for reads and turns off automatic EOI. The next data writes are taken as the vector base, then the cascade word, then the mode word (only if bit 0 of the starting command was 1). After that, data writes go to the mask again.
- R3: In normal operation a data write loads the mask, and a data-location read returns exactly the value written.
- R4: A rising edge on irq_in[n] sets pending bit n, and a low level on irq_in[n] clears it. An acknowledge clears the granted bit. A set mask bit does not clear the pending bit.
- R5: One cycle after ack, vec_valid is high for one cycle and vector is {base[7:3], n}, where base is the vector-base word.
- R6: Among unmasked pending inputs, the lowest index is granted.
- R7: int_req is high only while some unmasked pending input has a lower index than every in-service bit.
- R8: Without automatic EOI, an acknowledge sets in-service bit n of the granted input.
- R9: With mode-word bit 1 set, an acknowledge leaves the in-service register unchanged.
- R10: A command write of 0x60+n clears in-service bit n only.
- R11: A command write of 0x20 clears the lowest-index set in-service bit.
- R12: A command write of 0x0A selects the pending register for command reads, and 0x0B selects the in-service register.
- R13: An ack while int_req is low returns base+7 and leaves the in-service register unchanged, also when input 7 is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | 0 = command location, 1 = data location |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the location on addr |
| irq_in | input | 8 | Interrupt inputs, edge-sensed |
| ack | input | 1 | Acknowledge pulse from the processor |
| int_req | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after ack |
| vector | output | 8 | Delivered vector |

## Verification
The acknowledge path is tried with several request patterns. A single input shows the base-plus-index mapping. Two inputs raised together show which index wins. A request below an active in-service level is held off until a specific EOI clears the blocking level. A request that drops before the acknowledge produces the spurious vector, both with input 7 unmasked and with it masked. Setup runs three times: with normal EOI, with automatic EOI and a different base, and without the mode word. These runs show where each data write lands and that in-service bits are kept or dropped depending on the mode.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_e;

  localparam logic [2:0] OP_EOI_SPEC = 3'b011;
  localparam logic [2:0] OP_EOI_ANY  = 3'b001;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(DW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      imr_o,
  output logic [DW-IDX_W-1:0] base_o,
  output logic               aeoi_o,
  output logic               sel_isr_o,
  output logic               setup_o,
  output logic               run_o,
  output logic               eoi_spec_o,
  output logic               eoi_any_o,
  output logic [IDX_W-1:0]   eoi_lvl_o
);
  seq_e                 seq_q, seq_d;
  logic [DW-1:0]        imr_q, imr_d;
  logic [DW-IDX_W-1:0]  base_q, base_d;
  logic                 aeoi_q, aeoi_d;
  logic                 sel_q, sel_d;
  logic                 need_mode_q, need_mode_d;

  logic cmd_wr, dat_wr, is_start, is_sel, is_eoi;

  assign cmd_wr   = wr_en & ~addr;
  assign dat_wr   = wr_en & addr;
  assign is_start = cmd_wr & wdata[4];
  assign is_sel   = cmd_wr & ~wdata[4] & wdata[3];
  assign is_eoi   = cmd_wr & ~wdata[4] & ~wdata[3];

  always_comb begin
    seq_d       = seq_q;
    imr_d       = imr_q;
    base_d      = base_q;
    aeoi_d      = aeoi_q;
    sel_d       = sel_q;
    need_mode_d = need_mode_q;
    if (is_start) begin
      seq_d       = SEQ_BASE;
      imr_d       = '1;
      sel_d       = 1'b0;
      aeoi_d      = 1'b0;
      need_mode_d = wdata[0];
    end else begin
      if (is_sel && wdata[1]) sel_d = wdata[0];
      if (dat_wr) begin
        unique case (seq_q)
          SEQ_BASE: begin
            base_d = wdata[DW-1:IDX_W];
            seq_d  = SEQ_CASC;
          end
          SEQ_CASC: seq_d = need_mode_q ? SEQ_MODE : SEQ_RUN;
          SEQ_MODE: begin
            aeoi_d = wdata[1];
            seq_d  = SEQ_RUN;
          end
          default:  imr_d = wdata;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q       <= SEQ_RUN;
      imr_q       <= '1;
      base_q      <= '0;
      aeoi_q      <= 1'b0;
      sel_q       <= 1'b0;
      need_mode_q <= 1'b0;
    end else begin
      seq_q       <= seq_d;
      imr_q       <= imr_d;
      base_q      <= base_d;
      aeoi_q      <= aeoi_d;
      sel_q       <= sel_d;
      need_mode_q <= need_mode_d;
    end
  end

  assign imr_o      = imr_q;
  assign base_o     = base_q;
  assign aeoi_o     = aeoi_q;
  assign sel_isr_o  = sel_q;
  assign setup_o    = is_start;
  assign run_o      = (seq_q == SEQ_RUN);
  assign eoi_spec_o = is_eoi & (wdata[7:5] == OP_EOI_SPEC);
  assign eoi_any_o  = is_eoi & (wdata[7:5] == OP_EOI_ANY);
  assign eoi_lvl_o  = wdata[IDX_W-1:0];
endmodule

// File: rtl/pic_req.sv
module pic_req #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] irq_in,
  input  logic [DW-1:0] grant_clr,
  output logic [DW-1:0] irr_o
);
  logic [DW-1:0] prev_q, irr_q, irr_d;

  genvar g;
  generate
    for (g = 0; g < DW; g++) begin : g_line
      always_comb begin
        irr_d[g] = (irr_q[g] | (irq_in[g] & ~prev_q[g])) & irq_in[g] & ~grant_clr[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_in;
      irr_q  <= irr_d;
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(DW)
) (
  input  logic [DW-1:0]    irr,
  input  logic [DW-1:0]    imr,
  input  logic [DW-1:0]    isr,
  output logic             req_vld,
  output logic [IDX_W-1:0] req_idx,
  output logic             isr_vld,
  output logic [IDX_W-1:0] isr_idx,
  output logic             int_req
);
  logic [DW-1:0] open_req;
  assign open_req = irr & ~imr;

  always_comb begin
    req_vld = 1'b0;
    req_idx = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (open_req[i]) begin
        req_vld = 1'b1;
        req_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    isr_vld = 1'b0;
    isr_idx = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (isr[i]) begin
        isr_vld = 1'b1;
        isr_idx = IDX_W'(i);
      end
    end
  end

  assign int_req = req_vld & (~isr_vld | (req_idx < isr_idx));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] irq_in,
  input  logic          ack,
  output logic          int_req,
  output logic          vec_valid,
  output logic [DW-1:0] vector
);
  logic [DW-1:0]        imr;
  logic [DW-IDX_W-1:0]  base;
  logic                 aeoi, sel_isr, setup, cfg_run;
  logic                 eoi_spec, eoi_any;
  logic [IDX_W-1:0]     eoi_lvl;
  logic [DW-1:0]        irr_q, isr_q, isr_d;
  logic                 req_vld, isr_vld;
  logic [IDX_W-1:0]     req_idx, isr_idx;
  logic                 take;
  logic [DW-1:0]        take_vec, set_vec, clr_vec;
  logic                 vv_q, vv_d;
  logic [DW-1:0]        vec_q, vec_d;

  pic_cfg #(.DW(DW), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .imr_o(imr), .base_o(base), .aeoi_o(aeoi), .sel_isr_o(sel_isr),
    .setup_o(setup), .run_o(cfg_run), .eoi_spec_o(eoi_spec),
    .eoi_any_o(eoi_any), .eoi_lvl_o(eoi_lvl)
  );

  pic_req #(.DW(DW)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .grant_clr(take_vec), .irr_o(irr_q)
  );

  pic_arb #(.DW(DW), .IDX_W(IDX_W)) u_arb (
    .irr(irr_q), .imr(imr), .isr(isr_q), .req_vld(req_vld), .req_idx(req_idx),
    .isr_vld(isr_vld), .isr_idx(isr_idx), .int_req(int_req)
  );

  assign take     = ack & int_req;
  assign take_vec = take ? (DW'(1) << req_idx) : '0;
  assign set_vec  = aeoi ? '0 : take_vec;

  always_comb begin
    clr_vec = '0;
    if (eoi_spec) clr_vec = DW'(1) << eoi_lvl;
    else if (eoi_any && isr_vld) clr_vec = DW'(1) << isr_idx;
  end

  always_comb begin
    isr_d = setup ? '0 : ((isr_q | set_vec) & ~clr_vec);
    vv_d  = ack;
    vec_d = vec_q;
    if (ack) vec_d = {base, (take ? req_idx : {IDX_W{1'b1}})};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      vv_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      isr_q <= isr_d;
      vv_q  <= vv_d;
      vec_q <= vec_d;
    end
  end

  assign vec_valid = vv_q;
  assign vector    = vec_q;
  assign rdata     = addr ? imr : (sel_isr ? isr_q : irr_q);
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(DW)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr,
  input logic          wr_en,
  input logic [DW-1:0] wdata,
  input logic          ack,
  input logic          int_req,
  input logic          vec_valid,
  input logic [DW-1:0] vector,
  input logic [DW-1:0] irr_q,
  input logic [DW-1:0] isr_q,
  input logic [DW-1:0] imr,
  input logic          aeoi,
  input logic          cfg_run
);
  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && cfg_run) |=> (imr == $past(wdata)));

  // R5
  vec_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);

  // R5
  no_stray_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_valid);

  // R7
  req_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((irr_q & ~imr) != '0));

  // R13
  spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_req) |=> (vector[IDX_W-1:0] == {IDX_W{1'b1}}));

  // R9
  auto_eoi_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi && ack && !wr_en) |=> $stable(isr_q));

  // R10
  spec_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[7:3] == 5'b01100 && !ack)
      |=> ((isr_q & (DW'(1) << $past(wdata[IDX_W-1:0]))) == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.DW(DW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .ack(ack), .int_req(int_req), .vec_valid(vec_valid), .vector(vector),
  .irr_q(irr_q), .isr_q(isr_q), .imr(imr), .aeoi(aeoi), .cfg_run(cfg_run)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irq_in = 8'h00;
  logic       ack = 1'b0;
  logic       int_req;
  logic       vec_valid;
  logic [7:0] vector;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .ack(ack), .int_req(int_req),
    .vec_valid(vec_valid), .vector(vector)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(rdata, exp, tag);
  endtask

  task automatic req_chk(input logic exp, input string tag);
    @(negedge clk);
    check({7'd0, int_req}, {7'd0, exp}, tag);
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic do_ack(input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R5 actual=%02h expected=none (unexpected vector)", vector);
      end else begin
        check(vector, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(1'b1, 8'hFF, "R1 mask");
    rd_chk(1'b0, 8'h00, "R1 irr");
    req_chk(1'b0, "R1 int_req");
    check({7'd0, vec_valid}, 8'h00, "R1 vec_valid");

    // R2 setup with mode word, normal EOI
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd_chk(1'b1, 8'hFF, "R2 mask untouched by setup words");
    wr(1'b1, 8'h00);
    rd_chk(1'b1, 8'h00, "R3 mask readback");

    // R4 R5 R8 single request
    set_irq(8'h08);
    rd_chk(1'b0, 8'h08, "R4 irr edge");
    req_chk(1'b1, "R7 int_req raised");
    do_ack(8'h23, "R5 vector base+3");
    rd_chk(1'b0, 8'h00, "R4 ack clears irr");
    wr(1'b0, 8'h0B);
    rd_chk(1'b0, 8'h08, "R8 isr set");
    set_irq(8'h00);

    // R6 R7 R10 priority and nesting
    set_irq(8'h22);
    req_chk(1'b1, "R7 higher than in-service");
    do_ack(8'h21, "R6 lowest index wins");
    rd_chk(1'b0, 8'h0A, "R8 nested isr");
    req_chk(1'b0, "R7 blocked by isr");
    wr(1'b0, 8'h61);
    rd_chk(1'b0, 8'h08, "R10 specific eoi 1");
    req_chk(1'b0, "R7 still blocked by level 3");
    wr(1'b0, 8'h63);
    req_chk(1'b1, "R7 unblocked");
    do_ack(8'h25, "R6 remaining request");
    rd_chk(1'b0, 8'h20, "R8 isr level 5");
    wr(1'b0, 8'h20);
    rd_chk(1'b0, 8'h00, "R11 non-specific eoi");
    set_irq(8'h00);

    // R4 masking keeps pending bit
    wr(1'b0, 8'h0A);
    wr(1'b1, 8'h04);
    set_irq(8'h04);
    req_chk(1'b0, "R7 masked");
    rd_chk(1'b0, 8'h04, "R4 masked still pending");
    wr(1'b1, 8'h00);
    req_chk(1'b1, "R7 unmasked");
    do_ack(8'h22, "R5 vector base+2");
    wr(1'b0, 8'h62);
    set_irq(8'h00);

    // R13 spurious
    set_irq(8'h40);
    req_chk(1'b1, "R7 irq6");
    set_irq(8'h00);
    rd_chk(1'b0, 8'h00, "R4 drop clears irr");
    do_ack(8'h27, "R13 spurious vector");
    wr(1'b0, 8'h0B);
    rd_chk(1'b0, 8'h00, "R13 isr unchanged");
    wr(1'b1, 8'h80);
    do_ack(8'h27, "R13 spurious with ir7 masked");
    rd_chk(1'b0, 8'h00, "R13 isr unchanged masked");

    // R2 R9 R12 automatic EOI setup, new base
    wr(1'b0, 8'h11); wr(1'b1, 8'h28); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
    rd_chk(1'b1, 8'hFF, "R2 setup masks all");
    wr(1'b1, 8'h00);
    set_irq(8'h10);
    rd_chk(1'b0, 8'h10, "R12 setup selects irr");
    do_ack(8'h2C, "R5 new base");
    wr(1'b0, 8'h0B);
    rd_chk(1'b0, 8'h00, "R9 auto eoi isr empty");
    wr(1'b0, 8'h0A);
    rd_chk(1'b0, 8'h00, "R12 irr select");
    set_irq(8'h00);

    // R2 setup without mode word
    wr(1'b0, 8'h10); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h55);
    rd_chk(1'b1, 8'h55, "R2 third data write is mask");
    wr(1'b1, 8'h00);
    set_irq(8'h01);
    do_ack(8'h20, "R5 input 0");
    wr(1'b0, 8'h0B);
    rd_chk(1'b0, 8'h01, "R2 auto eoi off after setup");
    set_irq(8'h00);

    repeat (4) @(negedge clk);
    check(8'(exp_q.size()), 8'h00, "R5 all vectors seen");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule